// File: doc/BRIEF.md
# Power-of-Two Region Access Checker with Subregion Disables

This block decides, for every memory access, whether the access may go ahead under a table of eight protection regions. Each region is a naturally aligned, power-of-two sized window split into eight equal parts. Any of those parts can be switched off, so a region can fit a block whose size is not a power of two. Each region also carries an access-permission code and an execute-never attribute. The block compares the address against all slots in parallel. Where windows overlap, the slot with the highest number wins. The attributes of that slot then decide, from the access kind and the privilege level, whether the access is allowed.

Software programs the slots and the global controls through a simple registered write port. The allow/fault decision, the hit flag and the winning slot index are combinational from the request and the stored table. When a request is marked valid and denied, the block records its address, kind and privilege in a sticky fault record. That record holds until software clears it. A privileged access that hits no region can be let through by a background enable. An unprivileged access that misses always faults.

Top module: `prot_region_checker`

## Requirements
- R1: After reset every slot is disabled, the global enable and background enable are off, the fault flag is 0, and every access is allowed with `chk_hit` = 0.
- R2: While the global enable is off, `chk_allow` is 1 for every address, kind and privilege.
- R3: A slot with size code N (attribute bits [5:1]) covers 2^(N+1) bytes starting at its base. Codes below 4 act as 32 bytes, and base bits below the region size are ignored (base bits [4:0] are never stored).
- R4: Attribute bit 8+i disables the i-th eighth of a region, and an address in a disabled eighth does not match that slot. These bits are ignored for regions smaller than 256 bytes.
- R5: Attribute bit 0 enables a slot, and a disabled slot never matches.
- R6: When several slots match, the highest-numbered one is reported on `chk_region` with `chk_hit` = 1, and its attributes decide the access. With no match, `chk_hit` = 0 and `chk_region` = 0.
- R7: Permission code (attribute bits [18:16]): 000 and 100 give no access; 001 gives privileged read/write and no unprivileged access; 010 gives privileged read/write and unprivileged read; 011 gives read/write to both; 101 gives privileged read only; 110 and 111 give read only to both.
- R8: Access kind codes are 0 read, 1 write, 2 instruction fetch (3 acts as read). A fetch needs read permission and faults when the execute-never bit (attribute bit 20) of the winning slot is set.
- R9: On a miss with the global enable on, a privileged access is allowed only if the background enable is set, and an unprivileged access always faults.
- R10: A valid denied request, seen while the fault flag is clear, sets the flag and captures address, kind and privilege at the next clock edge. Later faults leave the record unchanged. Writing the clear bit drops the flag, and a fault in the same cycle as a clear is captured.
- R11: Config select 0 writes a slot base and select 1 writes a slot attribute word, both for the slot given by `cfg_slot`. Select 2 writes the controls: bit 0 global enable, bit 1 background enable, bit 2 clear fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 base, 1 attributes, 2 controls |
| cfg_slot | input | 3 | Slot index for base and attribute writes |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request is real; a denied valid request is recorded |
| req_addr | input | 32 | Access address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_priv | input | 1 | 1 for privileged access |
| chk_allow | output | 1 | Access allowed (0 means fault) |
| chk_hit | output | 1 | Some enabled slot matched |
| chk_region | output | 3 | Index of the winning slot |
| flt_flag | output | 1 | Sticky fault flag |
| flt_addr | output | 32 | Captured fault address |
| flt_kind | output | 2 | Captured access kind |
| flt_priv | output | 1 | Captured privilege level |

## Verification
The hardest case to reach is an address that lies inside a lower, coarser slot and inside a higher, finer slot at once. There the higher slot's disabled eighth must hand the decision back to the lower slot. A guard-sized slot stacked on top must still override both. The stimulus builds a nested table: a 64 KB read/write slot, a 4 KB read-only execute-never slot inside it with its last eighth disabled, and a 32-byte no-access slot inside that. It then probes addresses on each side of every eighth and guard boundary, with every access kind and both privilege levels. The case where a clear and a fault land in the same cycle is set up by driving a control write and a valid denied request on the same edge.

// File: rtl/prot_pkg.sv
package prot_pkg;

    // access kind codes on req_kind
    localparam logic [1:0] KIND_READ  = 2'd0;
    localparam logic [1:0] KIND_WRITE = 2'd1;
    localparam logic [1:0] KIND_FETCH = 2'd2;

    // configuration targets on cfg_sel
    localparam logic [1:0] CFG_BASE = 2'd0;
    localparam logic [1:0] CFG_ATTR = 2'd1;
    localparam logic [1:0] CFG_CTRL = 2'd2;

    // attribute word layout
    localparam int unsigned AT_EN_BIT   = 0;
    localparam int unsigned AT_SIZE_LO  = 1;
    localparam int unsigned AT_SIZE_HI  = 5;
    localparam int unsigned AT_SRD_LO   = 8;
    localparam int unsigned AT_SRD_HI   = 15;
    localparam int unsigned AT_AP_LO    = 16;
    localparam int unsigned AT_AP_HI    = 18;
    localparam int unsigned AT_XN_BIT   = 20;

    // control word layout
    localparam int unsigned CT_GLOB_BIT = 0;
    localparam int unsigned CT_BG_BIT   = 1;
    localparam int unsigned CT_CLR_BIT  = 2;

    // geometry
    localparam int unsigned SIZE_W        = AT_SIZE_HI - AT_SIZE_LO + 1;
    localparam int unsigned SUB_CNT       = 8;
    localparam int unsigned SUB_IDX_W     = $clog2(SUB_CNT);
    localparam int unsigned MIN_SIZE_CODE = 4;   // 32 bytes
    localparam int unsigned MIN_LOG2      = MIN_SIZE_CODE + 1;
    localparam int unsigned SUB_MIN_LOG2  = 8;   // subregions from 256 bytes

    typedef struct packed {
        logic                  en;
        logic [SIZE_W-1:0]     size;
        logic [SUB_CNT-1:0]    srd;
        logic [2:0]            ap;
        logic                  xn;
    } slot_attr_t;

endpackage

// File: rtl/prot_slot_match.sv
module prot_slot_match
    import prot_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [ADDR_W-1:0]  base,
    input  logic               en,
    input  logic [SIZE_W-1:0]  size,
    input  logic [SUB_CNT-1:0] srd,
    output logic               hit
);
    localparam int unsigned LOG_W = $clog2(ADDR_W + 1) + 1;

    logic [LOG_W-1:0]     log2_sz;
    logic [ADDR_W-1:0]    diff;
    logic                 upper_eq;
    logic [SUB_IDX_W-1:0] sub_idx;
    logic                 sub_off;

    always_comb begin
        if (size < SIZE_W'(MIN_SIZE_CODE)) begin
            log2_sz = LOG_W'(MIN_LOG2);
        end else begin
            log2_sz = LOG_W'(size) + LOG_W'(1);
        end
        diff = addr ^ base;
        if (log2_sz >= LOG_W'(ADDR_W)) begin
            upper_eq = 1'b1;
        end else begin
            upper_eq = ((diff >> log2_sz) == '0);
        end
        sub_idx = SUB_IDX_W'(addr >> (log2_sz - LOG_W'(SUB_IDX_W)));
        if (log2_sz >= LOG_W'(SUB_MIN_LOG2)) begin
            sub_off = srd[sub_idx];
        end else begin
            sub_off = 1'b0;
        end
        hit = en & upper_eq & ~sub_off;
    end
endmodule

// File: rtl/prot_prio_pick.sv
module prot_prio_pick #(
    parameter int unsigned NUM   = 8,
    parameter int unsigned IDX_W = $clog2(NUM)
) (
    input  logic [NUM-1:0]   hits,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < NUM; i++) begin
            if (hits[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/prot_perm_eval.sv
module prot_perm_eval (
    input  logic [2:0] ap,
    input  logic       xn,
    input  logic       priv,
    input  logic       is_write,
    input  logic       is_fetch,
    output logic       ok
);
    logic p_rd, p_wr, u_rd, u_wr, rd_ok, wr_ok;

    always_comb begin
        p_rd = 1'b0; p_wr = 1'b0; u_rd = 1'b0; u_wr = 1'b0;
        case (ap)
            3'b001: begin p_rd = 1'b1; p_wr = 1'b1; end
            3'b010: begin p_rd = 1'b1; p_wr = 1'b1; u_rd = 1'b1; end
            3'b011: begin p_rd = 1'b1; p_wr = 1'b1; u_rd = 1'b1; u_wr = 1'b1; end
            3'b101: begin p_rd = 1'b1; end
            3'b110,
            3'b111: begin p_rd = 1'b1; u_rd = 1'b1; end
            default: begin end
        endcase
        rd_ok = priv ? p_rd : u_rd;
        wr_ok = priv ? p_wr : u_wr;
        if (is_write) begin
            ok = wr_ok;
        end else begin
            ok = rd_ok & ~(is_fetch & xn);
        end
    end
endmodule

// File: rtl/prot_region_checker.sv
module prot_region_checker
    import prot_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 8,
    parameter int unsigned ADDR_W    = 32,
    localparam int unsigned IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [IDX_W-1:0]  cfg_slot,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_kind,
    input  logic              req_priv,
    output logic              chk_allow,
    output logic              chk_hit,
    output logic [IDX_W-1:0]  chk_region,
    output logic              flt_flag,
    output logic [ADDR_W-1:0] flt_addr,
    output logic [1:0]        flt_kind,
    output logic              flt_priv
);
    typedef struct packed {
        slot_attr_t [NUM_SLOTS-1:0]             attr;
        logic [NUM_SLOTS-1:0][ADDR_W-1:0]       base;
        logic                                   glob_en;
        logic                                   bg_en;
        logic                                   flag;
        logic [ADDR_W-1:0]                      f_addr;
        logic [1:0]                             f_kind;
        logic                                   f_priv;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_SLOTS-1:0] slot_hit;
    logic                 any_hit;
    logic [IDX_W-1:0]     win_idx;
    slot_attr_t           win_attr;
    logic                 is_write, is_fetch;
    logic                 perm_ok;
    logic                 allow_c;
    logic                 clr_req;
    logic                 flag_keep;
    logic                 glob_en_q, bg_en_q;

    // parallel slot comparators
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        prot_slot_match #(.ADDR_W(ADDR_W)) u_match (
            .addr (req_addr),
            .base (st_q.base[g]),
            .en   (st_q.attr[g].en),
            .size (st_q.attr[g].size),
            .srd  (st_q.attr[g].srd),
            .hit  (slot_hit[g])
        );
    end

    prot_prio_pick #(.NUM(NUM_SLOTS), .IDX_W(IDX_W)) u_pick (
        .hits (slot_hit),
        .any  (any_hit),
        .idx  (win_idx)
    );

    assign win_attr = st_q.attr[win_idx];
    assign is_write = (req_kind == KIND_WRITE);
    assign is_fetch = (req_kind == KIND_FETCH);

    prot_perm_eval u_perm (
        .ap       (win_attr.ap),
        .xn       (win_attr.xn),
        .priv     (req_priv),
        .is_write (is_write),
        .is_fetch (is_fetch),
        .ok       (perm_ok)
    );

    always_comb begin
        st_d = st_q;

        // access decision
        if (!st_q.glob_en) begin
            allow_c = 1'b1;
        end else if (any_hit) begin
            allow_c = perm_ok;
        end else begin
            allow_c = req_priv & st_q.bg_en;
        end

        // configuration writes
        clr_req = cfg_we && (cfg_sel == CFG_CTRL) && cfg_wdata[CT_CLR_BIT];
        if (cfg_we) begin
            case (cfg_sel)
                CFG_BASE: begin
                    st_d.base[cfg_slot] = {cfg_wdata[ADDR_W-1:MIN_LOG2], MIN_LOG2'(0)};
                end
                CFG_ATTR: begin
                    st_d.attr[cfg_slot].en   = cfg_wdata[AT_EN_BIT];
                    st_d.attr[cfg_slot].size = cfg_wdata[AT_SIZE_HI:AT_SIZE_LO];
                    st_d.attr[cfg_slot].srd  = cfg_wdata[AT_SRD_HI:AT_SRD_LO];
                    st_d.attr[cfg_slot].ap   = cfg_wdata[AT_AP_HI:AT_AP_LO];
                    st_d.attr[cfg_slot].xn   = cfg_wdata[AT_XN_BIT];
                end
                CFG_CTRL: begin
                    st_d.glob_en = cfg_wdata[CT_GLOB_BIT];
                    st_d.bg_en   = cfg_wdata[CT_BG_BIT];
                end
                default: begin end
            endcase
        end

        // sticky fault record
        flag_keep = st_q.flag & ~clr_req;
        st_d.flag = flag_keep;
        if (req_valid && !allow_c && !flag_keep) begin
            st_d.flag   = 1'b1;
            st_d.f_addr = req_addr;
            st_d.f_kind = req_kind;
            st_d.f_priv = req_priv;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign glob_en_q  = st_q.glob_en;
    assign bg_en_q    = st_q.bg_en;
    assign chk_allow  = allow_c;
    assign chk_hit    = any_hit;
    assign chk_region = win_idx;
    assign flt_flag   = st_q.flag;
    assign flt_addr   = st_q.f_addr;
    assign flt_kind   = st_q.f_kind;
    assign flt_priv   = st_q.f_priv;
endmodule

// File: rtl/prot_region_checker_sva.sv
module prot_region_checker_sva #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IDX_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              glob_en,
    input logic              bg_en,
    input logic              clr,
    input logic              req_valid,
    input logic              req_priv,
    input logic [ADDR_W-1:0] req_addr,
    input logic              chk_allow,
    input logic              chk_hit,
    input logic [IDX_W-1:0]  chk_region,
    input logic              flt_flag,
    input logic [ADDR_W-1:0] flt_addr
);
    AST_OFF_ALLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |-> chk_allow);  // R2

    AST_UNPRIV_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        glob_en && !chk_hit && !req_priv |-> !chk_allow);  // R9

    AST_BG_PRIV_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        glob_en && bg_en && !chk_hit && req_priv |-> chk_allow);  // R9

    AST_NOHIT_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_hit |-> chk_region == '0);  // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flt_flag && !clr |=> flt_flag);  // R10

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        flt_flag && !clr |=> $stable(flt_addr));  // R10

    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !chk_allow && (!flt_flag || clr)
        |=> flt_flag && (flt_addr == $past(req_addr)));  // R10
endmodule

bind prot_region_checker prot_region_checker_sva #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .glob_en    (glob_en_q),
    .bg_en      (bg_en_q),
    .clr        (clr_req),
    .req_valid  (req_valid),
    .req_priv   (req_priv),
    .req_addr   (req_addr),
    .chk_allow  (chk_allow),
    .chk_hit    (chk_hit),
    .chk_region (chk_region),
    .flt_flag   (flt_flag),
    .flt_addr   (flt_addr)
);

// File: tb/tb_prot_region_checker.sv
module tb_prot_region_checker;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [2:0]  cfg_slot = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_priv = 1'b0;
    logic        chk_allow, chk_hit, flt_flag, flt_priv;
    logic [2:0]  chk_region;
    logic [31:0] flt_addr;
    logic [1:0]  flt_kind;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prot_region_checker dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_slot(cfg_slot), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_kind(req_kind), .req_priv(req_priv),
        .chk_allow(chk_allow), .chk_hit(chk_hit), .chk_region(chk_region),
        .flt_flag(flt_flag), .flt_addr(flt_addr), .flt_kind(flt_kind), .flt_priv(flt_priv)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  kind;
        logic        priv;
        logic        allow;
        logic        hit;
        logic [2:0]  region;
    } vec_t;

    // kind: 0 read, 1 write, 2 fetch
    localparam vec_t VECS [21] = '{
        '{32'h0000_0100, 2'd0, 1'b0, 1'b1, 1'b1, 3'd0},  // R7 full access
        '{32'h0000_0100, 2'd2, 1'b0, 1'b1, 1'b1, 3'd0},  // R8 fetch no xn
        '{32'h0000_8010, 2'd0, 1'b0, 1'b1, 1'b1, 3'd1},  // R6 overlap read-only
        '{32'h0000_8010, 2'd1, 1'b1, 1'b0, 1'b1, 3'd1},  // R7 write to read-only
        '{32'h0000_8010, 2'd2, 1'b1, 1'b0, 1'b1, 3'd1},  // R8 xn fetch
        '{32'h0000_8E04, 2'd1, 1'b0, 1'b1, 1'b1, 3'd0},  // R4 disabled eighth falls to slot 0
        '{32'h0000_8DFC, 2'd1, 1'b0, 1'b0, 1'b1, 3'd1},  // R4 neighbour eighth still active
        '{32'h0000_8404, 2'd0, 1'b1, 1'b0, 1'b1, 3'd2},  // R6 guard slot
        '{32'h0000_8420, 2'd0, 1'b1, 1'b1, 1'b1, 3'd1},  // R3 just past guard
        '{32'h2000_0200, 2'd1, 1'b1, 1'b1, 1'b1, 3'd3},  // R7 priv-only rw
        '{32'h2000_0200, 2'd0, 1'b0, 1'b0, 1'b1, 3'd3},  // R7 unpriv denied
        '{32'h2000_0200, 2'd2, 1'b1, 1'b0, 1'b1, 3'd3},  // R8 xn fetch
        '{32'h2000_1010, 2'd0, 1'b1, 1'b0, 1'b0, 3'd0},  // R4 256B region eighth 0 off
        '{32'h2000_1020, 2'd0, 1'b1, 1'b1, 1'b1, 3'd4},  // R7 priv read-only
        '{32'h2000_1020, 2'd1, 1'b1, 1'b0, 1'b1, 3'd4},  // R7 priv write denied
        '{32'h2000_1020, 2'd0, 1'b0, 1'b0, 1'b1, 3'd4},  // R7 unpriv denied
        '{32'h3000_0000, 2'd1, 1'b0, 1'b1, 1'b1, 3'd5},  // R3 unaligned base, small code
        '{32'h3000_001F, 2'd0, 1'b0, 1'b1, 1'b1, 3'd5},  // R3 last byte of 32B
        '{32'h3000_0020, 2'd0, 1'b1, 1'b0, 1'b0, 3'd0},  // R3 first byte past
        '{32'h4000_0010, 2'd0, 1'b1, 1'b0, 1'b0, 3'd0},  // R5 disabled slot
        '{32'h0001_0000, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0}   // R9 miss, no background
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] attr(input logic en, input logic [4:0] sz,
                                         input logic [7:0] srd, input logic [2:0] ap,
                                         input logic xn);
        return 32'(en) | (32'(sz) << 1) | (32'(srd) << 8) | (32'(ap) << 16) | (32'(xn) << 20);
    endfunction

    task automatic cfg(input logic [1:0] sel, input logic [2:0] slot, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_slot = slot; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic probe(input logic [31:0] a, input logic [1:0] k, input logic p);
        @(negedge clk);
        req_addr = a; req_kind = k; req_priv = p;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        probe(32'h0000_8404, 2'd1, 1'b0);
        check("R1 flag after reset", 32'(flt_flag), 32'd0);
        check("R1 allow after reset", 32'(chk_allow), 32'd1);
        check("R1 no hit after reset", 32'(chk_hit), 32'd0);

        // R11 program the table
        cfg(2'd0, 3'd0, 32'h0000_0000); cfg(2'd1, 3'd0, attr(1, 5'd15, 8'h00, 3'b011, 0));
        cfg(2'd0, 3'd1, 32'h0000_8000); cfg(2'd1, 3'd1, attr(1, 5'd11, 8'h80, 3'b110, 1));
        cfg(2'd0, 3'd2, 32'h0000_8400); cfg(2'd1, 3'd2, attr(1, 5'd4,  8'hFF, 3'b000, 0));
        cfg(2'd0, 3'd3, 32'h2000_0000); cfg(2'd1, 3'd3, attr(1, 5'd9,  8'h00, 3'b001, 1));
        cfg(2'd0, 3'd4, 32'h2000_1000); cfg(2'd1, 3'd4, attr(1, 5'd7,  8'h01, 3'b101, 0));
        cfg(2'd0, 3'd5, 32'h3000_0010); cfg(2'd1, 3'd5, attr(1, 5'd3,  8'h00, 3'b011, 0));
        cfg(2'd0, 3'd6, 32'h4000_0000); cfg(2'd1, 3'd6, attr(0, 5'd11, 8'h00, 3'b011, 0));

        // R2 table loaded but global still off
        probe(32'h0000_8404, 2'd1, 1'b0);
        check("R2 global off allows guard", 32'(chk_allow), 32'd1);

        cfg(2'd2, 3'd0, 32'h1);

        foreach (VECS[i]) begin
            probe(VECS[i].addr, VECS[i].kind, VECS[i].priv);
            check($sformatf("table %0d allow (R3 R4 R5 R6 R7 R8 R9)", i),
                  32'(chk_allow), 32'(VECS[i].allow));
            check($sformatf("table %0d hit (R6)", i), 32'(chk_hit), 32'(VECS[i].hit));
            check($sformatf("table %0d region (R6)", i), 32'(chk_region), 32'(VECS[i].region));
        end

        // R8 reserved kind 3 behaves as read: read-only region, xn set, allowed
        probe(32'h0000_8010, 2'd3, 1'b0);
        check("R8 kind 3 as read", 32'(chk_allow), 32'd1);

        // R10 fault capture
        probe(32'h0000_0100, 2'd0, 1'b0);
        check("R10 flag clear before faults", 32'(flt_flag), 32'd0);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h0001_0000; req_kind = 2'd1; req_priv = 1'b0;
        @(negedge clk);
        req_addr = 32'h0000_8404; req_kind = 2'd0; req_priv = 1'b1;
        #1;
        check("R10 flag set", 32'(flt_flag), 32'd1);
        check("R10 captured addr", flt_addr, 32'h0001_0000);
        check("R10 captured kind", 32'(flt_kind), 32'd1);
        check("R10 captured priv", 32'(flt_priv), 32'd0);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check("R10 second fault ignored addr", flt_addr, 32'h0001_0000);
        check("R10 second fault ignored kind", 32'(flt_kind), 32'd1);
        cfg(2'd2, 3'd0, 32'h5);
        #1;
        check("R10 clear drops flag", 32'(flt_flag), 32'd0);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h0000_0100; req_kind = 2'd0; req_priv = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check("R10 allowed access leaves flag", 32'(flt_flag), 32'd0);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h0001_0000; req_kind = 2'd0;
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 32'h5;
        req_addr = 32'h0001_0004; req_kind = 2'd2; req_priv = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        #1;
        check("R10 clear with fault sets flag", 32'(flt_flag), 32'd1);
        check("R10 clear with fault addr", flt_addr, 32'h0001_0004);
        check("R10 clear with fault kind", 32'(flt_kind), 32'd2);
        check("R10 clear with fault priv", 32'(flt_priv), 32'd1);

        // R9 background enable
        cfg(2'd2, 3'd0, 32'h3);
        probe(32'h4000_0010, 2'd0, 1'b1);
        check("R9 priv miss with background", 32'(chk_allow), 32'd1);
        check("R9 miss reports no hit", 32'(chk_hit), 32'd0);
        probe(32'h4000_0010, 2'd0, 1'b0);
        check("R9 unpriv miss faults", 32'(chk_allow), 32'd0);
        probe(32'h2000_1010, 2'd1, 1'b1);
        check("R9 disabled eighth falls to background", 32'(chk_allow), 32'd1);

        // R2 global off again
        cfg(2'd2, 3'd0, 32'h0);
        probe(32'h0000_8404, 2'd1, 1'b0);
        check("R2 global off allows guard", 32'(chk_allow), 32'd1);
        probe(32'h2000_0200, 2'd2, 1'b0);
        check("R2 global off allows xn fetch", 32'(chk_allow), 32'd1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule